// File: doc/BRIEF.md
# Storage Host Error Interrupt Unit

This block gathers the fault conditions of a memory-card host controller into a bank of sticky per-cause flags and turns them into one interrupt line. Software selects which causes may interrupt through a mask register, and a global enable gates the line as a whole. Both start at zero, so nothing can interrupt until software arms the block. The card-side engine reports its own faults as single-cycle event pulses. These faults are response timeout, response error, data timeout, data CRC error, missing start bit, missing end bit and host starvation.

The block also polices two software-side actions and raises causes for them. The first is a one-entry command slot. Setting the start bit in the command register loads a command only when the slot is free. A start while a command is still waiting is dropped and raises the lock cause. The second is a data FIFO shared by software and the card engine. A software write to a full FIFO raises the overrun cause and stores nothing. A software read from an empty FIFO raises the underrun cause and returns zero.

The command slot is a two-state machine, `SLOT_FREE` and `SLOT_HELD`. The LOAD transition moves `SLOT_FREE` to `SLOT_HELD` on a start write. The ACCEPT transition moves `SLOT_HELD` back to `SLOT_FREE` on the engine's accept pulse. In `SLOT_HELD`, a start write is a COLLIDE. It discards the new command and pulses the lock cause.

Top module: `mch_err_intr`

## Requirements
- R1: After reset the control register (address 0) and mask register (address 1) read 0, the raw status (address 2) reads 0, `irq` is 0, `cmd_valid` is 0 and the status register (address 6) reads 0x001.
- R2: A one-cycle pulse on `card_evt[i]` (bit 0 response timeout, 1 response error, 2 data timeout, 3 data CRC, 4 missing start bit, 5 missing end bit, 6 starvation) sets raw bit i at the next clock edge, and the bit stays set with no further events.
- R3: Writing to address 2 clears exactly the raw bits written as 1. Bits written as 0 are unchanged. An event and a clear of the same bit in the same cycle leave the bit set.
- R4: `irq` is a register loaded with the control register's bit 0 AND the OR of (raw AND mask). It follows a change of enable or raw status one cycle later.
- R5: Address 3 reads raw AND mask in bits 9:0.
- R6: A write to address 4 with bit 31 set, while `cmd_valid` is 0, makes `cmd_valid` 1 and `cmd_word` equal wdata[15:0] from the next edge. A write with bit 31 clear does nothing.
- R7: A start write while `cmd_valid` is 1 sets raw bit 7 and leaves `cmd_word` unchanged, so the new command is lost.
- R8: A one-cycle `cmd_accept` makes `cmd_valid` 0, after which a start write loads again.
- R9: A software write to address 5 while the FIFO is full sets raw bit 8 and stores nothing.
- R10: A software read from address 5 while the FIFO is empty sets raw bit 9 and returns 0.
- R11: The status register at address 6 shows FIFO empty in bit 0, FIFO full in bit 1, `cmd_valid` in bit 2 and the FIFO fill level in bits 15:8.
- R12: Words leave the FIFO in the order they entered, whether software fills and the card drains, or the card fills and software drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| card_evt | input | 7 | Fault event pulses from the card engine |
| cmd_accept | input | 1 | Engine took the pending command |
| cmd_valid | output | 1 | Command slot holds a command |
| cmd_word | output | 16 | Held command |
| card_push | input | 1 | Engine writes a received word into the FIFO |
| card_pdata | input | 32 | Word written by the engine |
| card_pop | input | 1 | Engine takes a word from the FIFO |
| card_odata | output | 32 | FIFO head word for the engine |
| irq | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the card engine never pushes a word in the same cycle as a software data write, because the FIFO has one write port. They also assume that it pushes only when the FIFO has room. The stimulus drives card pushes only in phases where software makes no data writes, and it keeps card pushes within the FIFO depth. Event pulses, accept pulses and register strobes last one cycle each and change only on the falling clock edge.

// File: rtl/mch_err_pkg.sv
`timescale 1ns/1ps
package mch_err_pkg;
    localparam int NUM_EXT   = 7;
    localparam int NUM_CAUSE = 10;
    localparam int C_LOCK    = 7;
    localparam int C_OVR     = 8;
    localparam int C_UNR     = 9;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MASK = 3'd1,
        A_RAW  = 3'd2,
        A_VIEW = 3'd3,
        A_CMD  = 3'd4,
        A_DATA = 3'd5,
        A_STAT = 3'd6
    } reg_addr_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;
endpackage

// File: rtl/mch_cmd_slot.sv
`timescale 1ns/1ps
module mch_cmd_slot
    import mch_err_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_word,
    input  logic          accept,
    output logic          valid,
    output logic [CW-1:0] word,
    output logic          collide
);
    slot_state_e   state_q, state_d;
    logic [CW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (load)   state_d = SLOT_HELD;
            SLOT_HELD: if (accept) state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          word_q <= '0;
        else if (state_q == SLOT_FREE && load) word_q <= load_word;
    end

    always_comb begin
        valid   = 1'b0;
        collide = 1'b0;
        unique case (state_q)
            SLOT_FREE: valid = 1'b0;
            SLOT_HELD: begin
                valid   = 1'b1;
                collide = load;
            end
        endcase
    end

    assign word = word_q;
endmodule

// File: rtl/mch_sw_fifo.sv
`timescale 1ns/1ps
module mch_sw_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_push,
    input  logic [DW-1:0] sw_wdata,
    input  logic          sw_pop,
    input  logic          card_push,
    input  logic [DW-1:0] card_wdata,
    input  logic          card_pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level,
    output logic          ovr,
    output logic          unr
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;
    logic [DW-1:0] wdata;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == LW'(DEPTH));
    assign do_push = (sw_push || card_push) && !full;
    assign do_pop  = (sw_pop || card_pop) && !empty;
    assign wdata   = card_push ? card_wdata : sw_wdata;
    assign ovr     = sw_push && full;
    assign unr     = sw_pop && empty;
    assign head    = empty ? '0 : mem[rp_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mch_cause_bank.sv
`timescale 1ns/1ps
module mch_cause_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    input  logic         en,
    output logic [N-1:0] raw,
    output logic         irq
);
    logic [N-1:0] raw_q;
    logic         irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            irq_q <= 1'b0;
        end else begin
            raw_q <= (raw_q & ~clr) | set;
            irq_q <= en & (|(raw_q & mask));
        end
    end

    assign raw = raw_q;
    assign irq = irq_q;
endmodule

// File: rtl/mch_err_intr.sv
`timescale 1ns/1ps
module mch_err_intr
    import mch_err_pkg::*;
#(
    parameter int CW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_EXT-1:0]  card_evt,
    input  logic                cmd_accept,
    output logic                cmd_valid,
    output logic [CW-1:0]       cmd_word,
    input  logic                card_push,
    input  logic [DW-1:0]       card_pdata,
    input  logic                card_pop,
    output logic [DW-1:0]       card_odata,
    output logic                irq
);
    logic                 ctrl_en_q;
    logic [NUM_CAUSE-1:0] mask_q, raw_w, set_v, clr_v;
    logic                 cmd_load, collide;
    logic                 sw_push, sw_pop;
    logic                 fifo_empty, fifo_full, ovr, unr;
    logic [LW-1:0]        fifo_level;
    logic                 unused_bits;

    assign unused_bits = ^reg_wdata[30:CW];

    assign cmd_load = reg_wr && (reg_addr == A_CMD) && reg_wdata[31];
    assign sw_push  = reg_wr && (reg_addr == A_DATA);
    assign sw_pop   = reg_rd && (reg_addr == A_DATA);
    assign clr_v    = (reg_wr && reg_addr == A_RAW) ? reg_wdata[NUM_CAUSE-1:0] : '0;
    assign set_v    = {unr, ovr, collide, card_evt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            mask_q    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) ctrl_en_q <= reg_wdata[0];
            if (reg_addr == A_MASK) mask_q    <= reg_wdata[NUM_CAUSE-1:0];
        end
    end

    mch_cmd_slot #(.CW(CW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_load),
        .load_word (reg_wdata[CW-1:0]),
        .accept    (cmd_accept),
        .valid     (cmd_valid),
        .word      (cmd_word),
        .collide   (collide)
    );

    mch_sw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_push    (sw_push),
        .sw_wdata   (reg_wdata[DW-1:0]),
        .sw_pop     (sw_pop),
        .card_push  (card_push),
        .card_wdata (card_pdata),
        .card_pop   (card_pop),
        .head       (card_odata),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .level      (fifo_level),
        .ovr        (ovr),
        .unr        (unr)
    );

    mch_cause_bank #(.N(NUM_CAUSE)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .mask  (mask_q),
        .en    (ctrl_en_q),
        .raw   (raw_w),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[0] = ctrl_en_q;
            A_MASK: reg_rdata[NUM_CAUSE-1:0] = mask_q;
            A_RAW:  reg_rdata[NUM_CAUSE-1:0] = raw_w;
            A_VIEW: reg_rdata[NUM_CAUSE-1:0] = raw_w & mask_q;
            A_CMD: begin
                reg_rdata[31]     = cmd_valid;
                reg_rdata[CW-1:0] = cmd_word;
            end
            A_DATA: reg_rdata[DW-1:0] = card_odata;
            A_STAT: begin
                reg_rdata[0]      = fifo_empty;
                reg_rdata[1]      = fifo_full;
                reg_rdata[2]      = cmd_valid;
                reg_rdata[8 +: LW] = fifo_level;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mch_err_intr_chk.sv
`timescale 1ns/1ps
module mch_err_intr_chk #(
    parameter int N  = 10,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          cmd_accept,
    input logic          cmd_valid,
    input logic [CW-1:0] cmd_word,
    input logic          card_push,
    input logic          card_pop,
    input logic          irq,
    input logic          en,
    input logic [N-1:0]  raw,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  clr,
    input logic          f_empty,
    input logic          f_full
);
    logic start_wr, data_wr;
    assign start_wr = reg_wr && reg_addr == 3'd4 && reg_wdata[31];
    assign data_wr  = reg_wr && reg_addr == 3'd5;

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0));

    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en && ((raw & mask) != '0)));

    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept) |=> (cmd_valid && $stable(cmd_word)));

    p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && start_wr) |=> $stable(cmd_word));

    p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_full && data_wr && !card_pop) |=> f_full);

    p_one_writer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && card_push));

    p_card_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
        card_push |-> !f_full);
endmodule

bind mch_err_intr mch_err_intr_chk #(.N(mch_err_pkg::NUM_CAUSE), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cmd_accept (cmd_accept),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .card_push  (card_push),
    .card_pop   (card_pop),
    .irq        (irq),
    .en         (ctrl_en_q),
    .raw        (raw_w),
    .mask       (mask_q),
    .clr        (clr_v),
    .f_empty    (fifo_empty),
    .f_full     (fifo_full)
);

// File: tb/test_mch_err_intr.sv
`timescale 1ns/1ps
module test_mch_err_intr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  card_evt = '0;
    logic        cmd_accept = 1'b0;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        card_push = 1'b0;
    logic [31:0] card_pdata = '0;
    logic        card_pop = 1'b0;
    logic [31:0] card_odata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] rd;

    always #10 clk = ~clk;

    mch_err_intr i_mch_err_intr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_evt(card_evt), .cmd_accept(cmd_accept), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .card_push(card_push), .card_pdata(card_pdata),
        .card_pop(card_pop), .card_odata(card_odata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_evt(input logic [6:0] b);
        @(negedge clk);
        card_evt = b;
        @(negedge clk);
        card_evt = '0;
    endtask

    task automatic sw_fill(input logic [31:0] w, input bit expect_kept);
        if (expect_kept) exp_q.push_back(w);
        reg_write(3'd5, w);
    endtask

    // scoreboard monitor: compares each word the card engine takes
    always @(negedge clk) begin
        #2;
        if (card_pop) begin
            if (exp_q.size() == 0) check("R12 card pop with nothing expected", card_odata, 32'hx);
            else check("R12 card drain order", card_odata, exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 100000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read(3'd0, rd); check("R1 ctrl", rd, 0);
        reg_read(3'd1, rd); check("R1 mask", rd, 0);
        reg_read(3'd2, rd); check("R1 raw", rd, 0);
        reg_read(3'd6, rd); check("R1 status", rd, 32'h001);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 cmd_valid", {31'b0, cmd_valid}, 0);

        // R2 event capture and stickiness
        pulse_evt(7'b0000101);
        reg_read(3'd2, rd); check("R2 raw after events", rd, 32'h005);
        repeat (3) @(negedge clk);
        reg_read(3'd2, rd); check("R2 raw sticky", rd, 32'h005);
        pulse_evt(7'b1000000);
        reg_read(3'd2, rd); check("R2 starvation bit", rd, 32'h045);

        // R4 / R5 mask, enable and latency
        reg_write(3'd1, 32'h001);
        check("R4 no irq while disabled", {31'b0, irq}, 0);
        reg_read(3'd3, rd); check("R5 masked view", rd, 32'h001);
        reg_write(3'd0, 32'h1);
        check("R4 irq one cycle after enable", {31'b0, irq}, 0);
        @(negedge clk);
        check("R4 irq asserted", {31'b0, irq}, 1);

        // R3 write-one-to-clear, irq follows one cycle later
        reg_write(3'd2, 32'h001);
        check("R4 irq lags clear", {31'b0, irq}, 1);
        @(negedge clk);
        check("R4 irq drops", {31'b0, irq}, 0);
        reg_read(3'd2, rd); check("R3 selective clear", rd, 32'h044);
        reg_write(3'd2, 32'h000);
        reg_read(3'd2, rd); check("R3 zero write no effect", rd, 32'h044);
        @(negedge clk);
        card_evt = 7'b0000100; reg_addr = 3'd2; reg_wdata = 32'h004; reg_wr = 1'b1;
        @(negedge clk);
        card_evt = '0; reg_wr = 1'b0;
        reg_read(3'd2, rd); check("R3 set wins over clear", rd, 32'h044);
        reg_write(3'd2, 32'h3FF);
        reg_read(3'd2, rd); check("R3 clear all", rd, 0);

        // R6 command load
        reg_write(3'd4, 32'h0000_1234);
        check("R6 no start bit", {31'b0, cmd_valid}, 0);
        reg_write(3'd4, 32'h8000_1234);
        check("R6 cmd_valid", {31'b0, cmd_valid}, 1);
        check("R6 cmd_word", {16'b0, cmd_word}, 32'h1234);
        reg_read(3'd6, rd); check("R11 pending bit", rd, 32'h005);

        // R7 collision
        reg_write(3'd4, 32'h8000_5678);
        check("R7 word kept", {16'b0, cmd_word}, 32'h1234);
        reg_read(3'd2, rd); check("R7 lock cause", rd, 32'h080);
        reg_write(3'd2, 32'h3FF);

        // R8 accept then reload
        @(negedge clk); cmd_accept = 1'b1;
        @(negedge clk); cmd_accept = 1'b0;
        check("R8 slot freed", {31'b0, cmd_valid}, 0);
        reg_write(3'd4, 32'h8000_9ABC);
        check("R8 reload word", {16'b0, cmd_word}, 32'h9ABC);
        reg_read(3'd2, rd); check("R8 no lock on reload", rd, 0);
        @(negedge clk); cmd_accept = 1'b1;
        @(negedge clk); cmd_accept = 1'b0;

        // R9 / R11 / R12 software fill, overrun, card drain
        for (int i = 0; i < 4; i++) sw_fill(32'hA000_0000 + i, 1'b1);
        reg_read(3'd6, rd); check("R11 full status", rd, 32'h402);
        sw_fill(32'hDEAD_BEEF, 1'b0);
        reg_read(3'd2, rd); check("R9 overrun cause", rd, 32'h100);
        reg_read(3'd6, rd); check("R9 level unchanged", rd, 32'h402);
        @(negedge clk); card_pop = 1'b1;
        repeat (4) @(negedge clk);
        card_pop = 1'b0;
        check("R12 scoreboard drained", exp_q.size(), 0);
        reg_read(3'd6, rd); check("R11 empty status", rd, 32'h001);
        reg_write(3'd2, 32'h3FF);

        // R10 underrun with interrupt on that cause
        reg_write(3'd1, 32'h200);
        reg_read(3'd5, rd); check("R10 empty read data", rd, 0);
        reg_read(3'd2, rd); check("R10 underrun cause", rd, 32'h200);
        check("R10 irq from underrun", {31'b0, irq}, 1);
        reg_write(3'd2, 32'h3FF);

        // R12 card fills, software drains in order
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); card_push = 1'b1; card_pdata = 32'hC000_0010 + i;
        end
        @(negedge clk); card_push = 1'b0;
        for (int i = 0; i < 3; i++) begin
            reg_read(3'd5, rd); check("R12 software drain order", rd, 32'hC000_0010 + i);
        end
        reg_read(3'd2, rd); check("R10 no underrun on valid reads", rd, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule